// File: doc/BRIEF.md
# DRAM Distributed Refresh Scheduler and Arbiter

This block keeps every row of a DRAM array within its charge retention limit while sharing the memory with a CPU. A down-counting slot timer divides the retention period into equal slots. Each slot adds one owed refresh to a backlog counter. Whenever memory is free, the scheduler hands one owed refresh to the memory sequencer as a single-row request. An internal row pointer names the row, and the pointer steps once per acknowledged refresh.

CPU traffic normally has priority. An owed refresh waits while the CPU holds the memory or is asking for it. Once the backlog reaches its limit, the block enters drain mode. In drain mode CPU requests are withheld until every owed refresh has been served. A slot that ends while the backlog is already full sets a sticky warning flag. That point is the earliest at which a row could overrun its retention time.

The slot length is `SLOT = (RET_US * CLK_MHZ) / (ROWS + MAX_DEBT + 1)` cycles. This leaves room for a full backlog inside one retention period.

Top module: `dram_refresh_sched`

## Requirements
- R1: The first owed refresh is counted at the end of cycle SLOT-1 after reset release, and one more is counted every SLOT cycles after that. With an idle CPU, `ref_req` first rises in cycle SLOT+1, counting the first cycle after reset release as cycle 0.
- R2: `ref_req` rises in the cycle after a refresh is started. It stays high until a cycle in which `ref_done` is 1, and it is low in the following cycle. It is 0 out of reset.
- R3: `ref_row` is 0 out of reset. It advances by one on each acknowledged refresh and wraps from ROWS-1 to 0.
- R4: The backlog rises by one when a slot ends and falls by one on an acknowledged refresh. It never exceeds MAX_DEBT, and a refresh is started only while the backlog is non-zero.
- R5: Outside drain mode, `cpu_gnt` equals `cpu_req` whenever memory is free. A refresh starts only in a free cycle with `cpu_req` low.
- R6: Memory is not free while `mem_busy` is 1, while a refresh is in flight, or in the cycle after a `cpu_gnt`. In those cycles neither grant nor refresh start happens.
- R7: Drain mode begins when the backlog reaches MAX_DEBT and lasts while the backlog is non-zero. In drain mode `cpu_gnt` stays 0 and owed refreshes start in free cycles even if `cpu_req` is 1.
- R8: `ref_done` while `ref_req` is 0 has no effect on `ref_row` or on the backlog.
- R9: `stale_err` becomes 1 when a slot ends with the backlog at MAX_DEBT and no acknowledge in that cycle. It then stays 1 until reset.
- R10: Under mixed CPU traffic, with a three-cycle refresh acknowledge, the fraction of cycles with `ref_req` high stays below 10 percent.
- R11: `cpu_gnt` and `ref_req` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU asks for the memory |
| mem_busy | input | 1 | A CPU access is in progress |
| ref_done | input | 1 | Sequencer finished the requested row refresh |
| cpu_gnt | output | 1 | Memory granted to the CPU this cycle |
| ref_req | output | 1 | Refresh of `ref_row` requested, held until acknowledged |
| ref_row | output | clog2(ROWS) | Row to refresh |
| stale_err | output | 1 | Sticky retention warning |

## Verification
Several rules are checked by assertions on every cycle:
- the two grants never overlap;
- a request is held until it is acknowledged;
- the row pointer steps and wraps on each acknowledge and ignores stray acknowledges;
- the backlog stays within its cap, and a full backlog forces drain mode;
- the warning flag is sticky;
- a busy memory blocks the CPU grant.

The bench's scenarios show the rules that span many cycles. These are the exact slot timing of the first request, the starvation of refresh under constant CPU demand until drain mode takes over, overflow of the backlog while the memory is held busy, and the measured refresh overhead.

// File: rtl/dref_pkg.sv
package dref_pkg;
  typedef int unsigned uint_t;

  // cycles between owed refreshes, leaving room for a full backlog
  function automatic uint_t slot_cycles(uint_t ret_us, uint_t mhz, uint_t rows, uint_t max_debt);
    return (ret_us * mhz) / (rows + max_debt + 1);
  endfunction

  function automatic uint_t row_after(uint_t row, uint_t rows);
    return (row == rows - 1) ? 0 : row + 1;
  endfunction
endpackage

// File: rtl/dref_slot_timer.sv
module dref_slot_timer #(
  parameter int unsigned SLOT = 387
) (
  input  logic clk,
  input  logic rst_n,
  output logic slot_end
);
  localparam int unsigned TW = (SLOT > 1) ? $clog2(SLOT) : 1;

  logic [TW-1:0] cnt_q;

  assign slot_end = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= TW'(SLOT - 1);
    else if (slot_end) cnt_q <= TW'(SLOT - 1);
    else               cnt_q <= cnt_q - 1'b1;
  end

  // R1: slot ends are spaced, never back to back
  assert_slot_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> !slot_end);
endmodule

// File: rtl/dref_backlog.sv
module dref_backlog #(
  parameter int unsigned MAX_DEBT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_end,
  input  logic done_ok,
  output logic owed,
  output logic urgent,
  output logic overflow_err
);
  localparam int unsigned DW = $clog2(MAX_DEBT + 1);
  localparam logic [DW-1:0] FULL = DW'(MAX_DEBT);

  logic [DW-1:0] debt_q;
  logic          drain_q;
  logic          err_q;
  logic          full;
  logic          overflow;

  assign full         = (debt_q == FULL);
  assign overflow     = slot_end && !done_ok && full;
  assign owed         = (debt_q != '0);
  assign urgent       = full || (drain_q && owed);
  assign overflow_err = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      debt_q  <= '0;
      drain_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (overflow) err_q <= 1'b1;
      if (full)       drain_q <= 1'b1;
      else if (!owed) drain_q <= 1'b0;
      case ({slot_end, done_ok})
        2'b10:   if (!full) debt_q <= debt_q + 1'b1;
        2'b01:   debt_q <= debt_q - 1'b1;
        default: debt_q <= debt_q;
      endcase
    end
  end

  // R4: backlog stays within its cap
  assert_debt_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    debt_q <= FULL);
  // R4: an acknowledge only arrives for an owed refresh
  assert_done_owed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |-> owed);
  // R7: a full backlog leaves drain mode active next cycle
  assert_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> urgent);
endmodule

// File: rtl/dref_grant.sv
module dref_grant (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req,
  input  logic mem_busy,
  input  logic owed,
  input  logic urgent,
  input  logic ref_done,
  output logic cpu_gnt,
  output logic ref_act,
  output logic done_ok
);
  logic act_q;
  logic gnt_q;
  logic free;
  logic start;

  assign free    = !mem_busy && !act_q && !gnt_q;
  assign cpu_gnt = cpu_req && free && !urgent;
  assign start   = owed && free && (urgent || !cpu_req);
  assign done_ok = ref_done && act_q;
  assign ref_act = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      gnt_q <= 1'b0;
    end else begin
      gnt_q <= cpu_gnt;
      if (start)        act_q <= 1'b1;
      else if (done_ok) act_q <= 1'b0;
    end
  end

  // R6: the cycle after a CPU grant is reserved
  assert_gnt_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_gnt |=> !cpu_gnt && !ref_act);
  // R5: a refresh start never overrides a CPU request outside drain mode
  assert_cpu_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !urgent && !act_q) |=> !ref_act);
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dref_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 100,
  parameter int unsigned RET_US   = 4000,
  parameter int unsigned ROWS     = 1024,
  parameter int unsigned MAX_DEBT = 8,
  localparam int unsigned ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             mem_busy,
  input  logic             ref_done,
  output logic             cpu_gnt,
  output logic             ref_req,
  output logic [ROW_W-1:0] ref_row,
  output logic             stale_err
);
  localparam uint_t SLOT = slot_cycles(RET_US, CLK_MHZ, ROWS, MAX_DEBT);

  logic slot_end;
  logic owed;
  logic urgent;
  logic done_ok;
  logic [ROW_W-1:0] row_q;

  dref_slot_timer #(.SLOT(SLOT)) u_timer (
    .clk(clk), .rst_n(rst_n), .slot_end(slot_end)
  );

  dref_backlog #(.MAX_DEBT(MAX_DEBT)) u_backlog (
    .clk(clk), .rst_n(rst_n), .slot_end(slot_end), .done_ok(done_ok),
    .owed(owed), .urgent(urgent), .overflow_err(stale_err)
  );

  dref_grant u_grant (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .mem_busy(mem_busy),
    .owed(owed), .urgent(urgent), .ref_done(ref_done),
    .cpu_gnt(cpu_gnt), .ref_act(ref_req), .done_ok(done_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       row_q <= '0;
    else if (done_ok) row_q <= ROW_W'(row_after(uint_t'(row_q), ROWS));
  end
  assign ref_row = row_q;

  // R11: grants are exclusive
  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_gnt && ref_req));
  // R2: request held until acknowledged, dropped after
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_done) |=> ref_req);
  assert_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_done) |=> !ref_req);
  // R3: row steps with wrap on acknowledge
  assert_row_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_done) |=> ref_row == ROW_W'(row_after(uint_t'($past(ref_row)), ROWS)));
  // R8: stray acknowledge leaves the row untouched
  assert_stray_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_req && ref_done) |=> $stable(ref_row));
  // R6: busy memory blocks the CPU grant
  assert_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_busy |-> !cpu_gnt);
  // R9: warning is sticky
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stale_err |=> stale_err);
endmodule

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
  localparam int MHZ = 100, RUS = 40, NROWS = 16, MAXD = 8;
  localparam int SLOTC = (RUS * MHZ) / (NROWS + MAXD + 1); // 160
  localparam int DLAT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 1'b0, mem_busy = 1'b0, ref_done = 1'b0;
  logic cpu_gnt, ref_req, stale_err;
  logic [3:0] ref_row;

  always #5 clk = ~clk;

  dram_refresh_sched #(.CLK_MHZ(MHZ), .RET_US(RUS), .ROWS(NROWS), .MAX_DEBT(MAXD)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .mem_busy(mem_busy), .ref_done(ref_done),
    .cpu_gnt(cpu_gnt), .ref_req(ref_req), .ref_row(ref_row), .stale_err(stale_err));

  int total = 0, bad = 0;
  // reference model state
  int m_cyc, m_debt, m_row;
  bit m_drain, m_act, m_gq, m_err;
  // stimulus control
  int mode = 0;          // 0 idle, 1 light, 2 heavy, 3 hog, 4 stray
  int busy_left = 0, dcnt = 0, blen = 3;
  bit gnt_seen = 0, stray_pend = 0;
  logic [3:0] stray_row;
  int cyc = 0, first_req = -1, prev_rise = -1, gap_bad = 0, gaps = 0;
  int wraps = 0, meas = 0, ref_cyc = 0, meas_cyc = 0, urg_blocks = 0;
  bit last_req = 0;
  logic [3:0] last_row = 0;

  function automatic bit m_urg();
    return (m_debt == MAXD) || (m_drain && m_debt != 0);
  endfunction
  function automatic bit m_free();
    return !mem_busy && !m_act && !m_gq;
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // model update on each clock edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cyc = 0; m_debt = 0; m_row = 0;
      m_drain = 0; m_act = 0; m_gq = 0; m_err = 0;
    end else begin
      bit tick, dok, g, st, u;
      tick = (m_cyc % SLOTC) == SLOTC - 1;
      dok  = ref_done && m_act;
      u    = m_urg();
      g    = cpu_req && m_free() && !u;
      st   = (m_debt != 0) && m_free() && (u || !cpu_req);
      if (tick && !dok && m_debt == MAXD) m_err = 1;
      if (m_debt == MAXD) m_drain = 1; else if (m_debt == 0) m_drain = 0;
      if (tick && !dok) begin if (m_debt < MAXD) m_debt++; end
      else if (dok && !tick) m_debt--;
      if (dok) m_row = (m_row + 1) % NROWS;
      if (st) m_act = 1; else if (dok) m_act = 0;
      m_gq = g;
      m_cyc++;
    end
  end

  // drive at negedge+1, compare at negedge+3
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      ref_done = 1'b0;
      if (ref_req) begin dcnt++; if (dcnt == DLAT) ref_done = 1'b1; end
      else begin
        dcnt = 0;
        if (mode == 4 && ($urandom % 4) == 0) begin
          ref_done = 1'b1; stray_pend = 1; stray_row = ref_row;
        end
      end
      if (gnt_seen) begin cpu_req = 1'b0; busy_left = blen; end
      if (mode == 1 && !cpu_req && busy_left == 0 && ($urandom % 10) < 3) begin
        cpu_req = 1'b1; blen = 1 + int'($urandom % 6);
      end
      if (mode == 2 && busy_left == 0 && !gnt_seen) begin cpu_req = 1'b1; blen = 5; end
      mem_busy = (mode == 3) || (busy_left > 0);
      if (busy_left > 0) busy_left--;
    end
    #2;
    if (rst_n) begin
      bit eg;
      eg = cpu_req && m_free() && !m_urg();
      check(cpu_gnt === eg, "R5,R6,R7 cpu_gnt", int'(cpu_gnt), int'(eg));
      check(ref_req === m_act, "R2,R4 ref_req", int'(ref_req), int'(m_act));
      check(int'(ref_row) == m_row, "R3 ref_row", int'(ref_row), m_row);
      check(stale_err === m_err, "R9 stale_err", int'(stale_err), int'(m_err));
      check(!(cpu_gnt && ref_req), "R11 exclusive grants", int'(cpu_gnt & ref_req), 0);
      if (stray_pend && !ref_done) begin
        check(ref_row == stray_row, "R8 stray acknowledge", int'(ref_row), int'(stray_row));
        stray_pend = 0;
      end
      if (ref_req && !last_req) begin
        if (first_req < 0) first_req = cyc;
        if (mode == 0 && prev_rise >= 0) begin gaps++; if (cyc - prev_rise != SLOTC) gap_bad++; end
        prev_rise = cyc;
      end
      if (last_row == 4'(NROWS - 1) && ref_row == 0) wraps++;
      if (mode == 2 && cpu_req && !cpu_gnt && m_free() && m_urg()) urg_blocks++;
      if (meas) begin meas_cyc++; if (ref_req) ref_cyc++; end
      gnt_seen = cpu_gnt;
      last_req = ref_req;
      last_row = ref_row;
      cyc++;
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000", wd);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(cpu_gnt === 1'b0 && ref_req === 1'b0, "R2 reset outputs", int'(ref_req), 0);
    check(ref_row == 0, "R3 reset row", int'(ref_row), 0);
    check(stale_err === 1'b0, "R9 reset flag", int'(stale_err), 0);
    @(negedge clk); rst_n = 1'b1;
    // idle: regular slots, row wrap
    mode = 0; meas = 1;
    repeat (20 * SLOTC) @(posedge clk);
    check(first_req == SLOTC + 1, "R1 first request cycle", first_req, SLOTC + 1);
    check(gaps > 10 && gap_bad == 0, "R1 idle spacing", gap_bad, 0);
    check(wraps >= 1, "R3 row wrap seen", wraps, 1);
    // light mixed traffic
    mode = 1;
    repeat (50 * SLOTC) @(posedge clk);
    mode = 0; repeat (20) @(posedge clk);
    meas = 0;
    check(ref_cyc * 100 < 10 * meas_cyc, "R10 overhead percent", ref_cyc * 100 / meas_cyc, 10);
    // stray acknowledges
    mode = 4;
    repeat (10 * SLOTC) @(posedge clk);
    mode = 0; repeat (20) @(posedge clk);
    // constant CPU demand: drain mode
    mode = 2;
    repeat (20 * SLOTC) @(posedge clk);
    mode = 0; repeat (40) @(posedge clk);
    check(urg_blocks > 0, "R7 CPU withheld in drain", urg_blocks, 1);
    check(stale_err === 1'b0, "R9 no warning before overflow", int'(stale_err), 0);
    // memory held busy: backlog overflows
    mode = 3;
    repeat (11 * SLOTC) @(posedge clk);
    mode = 0;
    #1;
    check(stale_err === 1'b1, "R9 warning after overflow", int'(stale_err), 1);
    repeat (12 * SLOTC) @(posedge clk);
    #1;
    check(stale_err === 1'b1, "R9 warning sticky", int'(stale_err), 1);
    check(ref_req === 1'b0, "R4 backlog drained to idle", int'(ref_req), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule